// File: doc/BRIEF.md
# Multi-Rail Power Sequencing Controller

This block brings a set of supply rails up one at a time and takes them down again in the opposite order. A single run-command level starts the power-on walk. Each rail has a "good" level that comes from an external threshold comparator, and the controller watches it to learn when that rail has settled. A programmable delay is inserted before the first rail, and again after each rail settles. After the last rail reports good, a done flag rises.

Dropping the run command after done starts the descent. The highest rail is released first, and each lower rail follows once the rail above it has gone below its off level and the delay has run out. Power-on has a power-good watchdog for each rail. It starts when a rail is enabled and raises a timeout pulse if that rail does not report good in time. A configuration input can switch the watchdog off. A per-rail hysteresis flag records which rails have been seen good, so the external comparator can move to its lower off threshold.

A fault-shutdown input from a separate supervisor forces every enable low in the same cycle. The block itself does not latch faults. It reports timeout events and run-command ordering errors to the supervisor as one-cycle pulses.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: After synchronous reset, every output is low: all rail enables, all hysteresis flags, done, timeout and sequence-error pulses.
- R2: A rising run command is seen through a two-flop synchronizer. Rail 0 (bit 0 of the enable vector) turns on D+4 cycles after run_i rises, where D is the programmed delay. At most one enable rises per cycle, and rail k never rises while rail k-1 is off.
- R3: During power-on, the next rail turns on D+4 cycles after the current rail's good input rises. D=0 is valid and gives 4 cycles.
- R4: A rail's hysteresis flag (hyst_en_o bit k) rises 3 cycles after its good input rises during power-on. It falls 3 cycles after that input falls during power-off.
- R5: done_o rises 3 cycles after the good input of the last rail (bit 3) rises, at which point all enables and flags are high. It falls 3 cycles after rail 0's good input falls during power-off.
- R6: Power-off starts only from the completed state. Rail 3 drops 3 cycles after run_i falls. Each lower rail k-1 drops D+4 cycles after rail k's good input falls, so the order is 3, 2, 1, 0.
- R7: The watchdog restarts with limit P each time a rail turns on during power-on. If the rail's good input is not seen in time, pg_timeout_o pulses for one cycle, P+1 cycles after the enable rose, and it pulses only once for that rail.
- R8: With pg_enable_i low, no timeout pulse occurs. No timeout pulse occurs during power-off, however long a rail's good input stays high.
- R9: While fault_kill_i is high, every rail enable is low in that same cycle. From the next cycle the hysteresis flags and done are cleared as well, and sequencing restarts only after run_i has been seen low.
- R10: If run_i falls during power-on, or rises during power-off, seq_err_o pulses for one cycle 3 cycles later. In that same cycle all enables, flags and done drop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | Run command level (asynchronous) |
| rail_good_i | input | NR | Per-rail good levels from comparators (asynchronous) |
| fault_kill_i | input | 1 | Fault-shutdown from the supervisor, synchronous, forces enables low |
| pg_enable_i | input | 1 | Enables the power-good watchdog |
| dly_cycles_i | input | DLY_W | Inter-rail delay in cycles |
| pg_cycles_i | input | PG_W | Power-good watchdog limit in cycles |
| rail_en_o | output | NR | Rail enables |
| hyst_en_o | output | NR | Per-rail hysteresis-enable flags |
| done_o | output | 1 | Power-on complete |
| pg_timeout_o | output | 1 | One-cycle watchdog timeout event |
| seq_err_o | output | 1 | One-cycle run-command ordering error event |
| pg_busy_o | output | 1 | Watchdog counter running |

## Verification
The hardest conditions to reach are the two error paths: a watchdog expiry, and a run-command reversal in the middle of the descent. Neither happens while the bench answers every enable promptly. The stimulus therefore holds a rail's good input back past a short programmed watchdog limit and checks the exact cycle of the pulse. It also reasserts run_i while the top rail is still reporting good partway through power-off. Every expected output change, including its cycle, is queued when the bench drives the stimulus, so any extra pulse is caught as an unexpected change. That covers a stray timeout while the watchdog is disabled or during the descent.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    // Sequencer states
    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_UP_DLY  = 3'd1,
        ST_UP_WAIT = 3'd2,
        ST_ON      = 3'd3,
        ST_DN_WAIT = 3'd4,
        ST_DN_DLY  = 3'd5,
        ST_HALT    = 3'd6
    } seq_state_t;

endpackage

// File: rtl/pseq_sync.sv
module pseq_sync #(
    parameter int W      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);

    logic [W-1:0] stage_q [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= '0;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];

endmodule

// File: rtl/pseq_tmr.sv
module pseq_tmr #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load_i,
    input  logic          clear_i,
    input  logic [CW-1:0] limit_i,
    output logic          expired_o,
    output logic          busy_o
);

    logic [CW-1:0] cnt_d, cnt_q;
    logic          busy_d, busy_q;

    assign expired_o = busy_q && (cnt_q == '0);
    assign busy_o    = busy_q;

    always_comb begin
        cnt_d  = cnt_q;
        busy_d = busy_q;
        if (load_i) begin
            cnt_d  = limit_i;
            busy_d = 1'b1;
        end else if (clear_i || expired_o) begin
            busy_d = 1'b0;
        end else if (busy_q) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            busy_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            busy_q <= busy_d;
        end
    end

endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
    import pwr_seq_pkg::*;
#(
    parameter int NR          = 4,
    parameter int DLY_W       = 16,
    parameter int PG_W        = 20,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run_i,
    input  logic [NR-1:0]    rail_good_i,
    input  logic             fault_kill_i,
    input  logic             pg_enable_i,
    input  logic [DLY_W-1:0] dly_cycles_i,
    input  logic [PG_W-1:0]  pg_cycles_i,
    output logic [NR-1:0]    rail_en_o,
    output logic [NR-1:0]    hyst_en_o,
    output logic             done_o,
    output logic             pg_timeout_o,
    output logic             seq_err_o,
    output logic             pg_busy_o
);

    localparam int IW = (NR > 1) ? $clog2(NR) : 1;
    localparam logic [IW-1:0] LAST = IW'(NR - 1);

    typedef struct packed {
        seq_state_t    st;
        logic [IW-1:0] idx;
        logic [NR-1:0] en;
        logic [NR-1:0] hyst;
        logic          done;
        logic          pgto;
        logic          serr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic [NR:0]   sync_q;
    logic          run_s;
    logic [NR-1:0] good_s;
    logic          dly_load, dly_clr, dly_exp, dly_busy;
    logic          pg_load, pg_clr, pg_exp;
    logic          good_cur;
    logic [IW-1:0] idx_up, idx_dn;

    // Two-flop synchronizers for the level inputs
    pseq_sync #(.W(NR + 1), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({run_i, rail_good_i}),
        .q_o (sync_q)
    );

    assign run_s  = sync_q[NR];
    assign good_s = sync_q[NR-1:0];

    // Inter-rail delay counter
    pseq_tmr #(.CW(DLY_W)) u_dly (
        .clk       (clk),
        .rst       (rst),
        .load_i    (dly_load),
        .clear_i   (dly_clr),
        .limit_i   (dly_cycles_i),
        .expired_o (dly_exp),
        .busy_o    (dly_busy)
    );

    // Power-good watchdog counter
    pseq_tmr #(.CW(PG_W)) u_pg (
        .clk       (clk),
        .rst       (rst),
        .load_i    (pg_load),
        .clear_i   (pg_clr),
        .limit_i   (pg_cycles_i),
        .expired_o (pg_exp),
        .busy_o    (pg_busy_o)
    );

    assign good_cur = good_s[ctl_q.idx];
    assign idx_up   = ctl_q.idx + 1'b1;
    assign idx_dn   = ctl_q.idx - 1'b1;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.pgto = 1'b0;
        ctl_d.serr = 1'b0;
        dly_load   = 1'b0;
        pg_load    = 1'b0;
        dly_clr    = !((ctl_q.st == ST_UP_DLY) || (ctl_q.st == ST_DN_DLY));
        pg_clr     = (ctl_q.st != ST_UP_WAIT);

        if (fault_kill_i) begin
            ctl_d.st   = ST_HALT;
            ctl_d.idx  = '0;
            ctl_d.en   = '0;
            ctl_d.hyst = '0;
            ctl_d.done = 1'b0;
        end else begin
            case (ctl_q.st)
                ST_IDLE: begin
                    if (run_s) begin
                        ctl_d.idx = '0;
                        dly_load  = 1'b1;
                        ctl_d.st  = ST_UP_DLY;
                    end
                end
                ST_UP_DLY, ST_UP_WAIT: begin
                    if (!run_s) begin
                        ctl_d.st   = ST_HALT;
                        ctl_d.en   = '0;
                        ctl_d.hyst = '0;
                        ctl_d.done = 1'b0;
                        ctl_d.serr = 1'b1;
                    end else if (ctl_q.st == ST_UP_DLY) begin
                        if (dly_exp) begin
                            ctl_d.en[ctl_q.idx] = 1'b1;
                            pg_load             = pg_enable_i;
                            ctl_d.st            = ST_UP_WAIT;
                        end
                    end else if (good_cur) begin
                        ctl_d.hyst[ctl_q.idx] = 1'b1;
                        pg_clr                = 1'b1;
                        if (ctl_q.idx == LAST) begin
                            ctl_d.done = 1'b1;
                            ctl_d.st   = ST_ON;
                        end else begin
                            ctl_d.idx = idx_up;
                            dly_load  = 1'b1;
                            ctl_d.st  = ST_UP_DLY;
                        end
                    end else if (pg_exp) begin
                        ctl_d.pgto = 1'b1;
                    end
                end
                ST_ON: begin
                    if (!run_s) begin
                        ctl_d.en[LAST] = 1'b0;
                        ctl_d.idx      = LAST;
                        ctl_d.st       = ST_DN_WAIT;
                    end
                end
                ST_DN_WAIT, ST_DN_DLY: begin
                    if (run_s) begin
                        ctl_d.st   = ST_HALT;
                        ctl_d.en   = '0;
                        ctl_d.hyst = '0;
                        ctl_d.done = 1'b0;
                        ctl_d.serr = 1'b1;
                    end else if (ctl_q.st == ST_DN_WAIT) begin
                        if (!good_cur) begin
                            ctl_d.hyst[ctl_q.idx] = 1'b0;
                            if (ctl_q.idx == '0) begin
                                ctl_d.done = 1'b0;
                                ctl_d.st   = ST_IDLE;
                            end else begin
                                dly_load = 1'b1;
                                ctl_d.st = ST_DN_DLY;
                            end
                        end
                    end else if (dly_exp) begin
                        ctl_d.idx        = idx_dn;
                        ctl_d.en[idx_dn] = 1'b0;
                        ctl_d.st         = ST_DN_WAIT;
                    end
                end
                ST_HALT: begin
                    ctl_d.en   = '0;
                    ctl_d.hyst = '0;
                    ctl_d.done = 1'b0;
                    if (!run_s) ctl_d.st = ST_IDLE;
                end
                default: ctl_d.st = ST_HALT;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ctl_q <= '0;
        else     ctl_q <= ctl_d;
    end

    assign rail_en_o    = ctl_q.en & ~{NR{fault_kill_i}};
    assign hyst_en_o    = ctl_q.hyst;
    assign done_o       = ctl_q.done;
    assign pg_timeout_o = ctl_q.pgto;
    assign seq_err_o    = ctl_q.serr;

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int NR = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          fault_kill_i,
    input logic [NR-1:0] rail_en_o,
    input logic [NR-1:0] hyst_en_o,
    input logic          done_o,
    input logic          pg_timeout_o,
    input logic          seq_err_o
);

    // R9
    kill_blanks_chk: assert property (@(posedge clk) disable iff (rst)
        fault_kill_i |-> (rail_en_o == '0));

    // R2
    single_rise_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rail_en_o & ~$past(rail_en_o)) <= 1);

    genvar k;
    generate
        for (k = 1; k < NR; k++) begin : g_order
            // R2
            up_order_chk: assert property (@(posedge clk) disable iff (rst)
                $rose(rail_en_o[k]) |-> rail_en_o[k-1]);
            // R6
            dn_order_chk: assert property (@(posedge clk) disable iff (rst)
                $fell(rail_en_o[k-1]) |-> !rail_en_o[k]);
        end
    endgenerate

    // R5
    done_full_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(done_o) |-> ((&rail_en_o) && (&hyst_en_o)));

    // R7
    tmo_pending_chk: assert property (@(posedge clk) disable iff (rst)
        pg_timeout_o |-> ($countones(rail_en_o) == $countones(hyst_en_o) + 1));

    // R10
    serr_drop_chk: assert property (@(posedge clk) disable iff (rst)
        seq_err_o |-> ((rail_en_o == '0) && !done_o));

endmodule

bind pwr_seq_ctrl pwr_seq_chk #(.NR(NR)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .fault_kill_i (fault_kill_i),
    .rail_en_o    (rail_en_o),
    .hyst_en_o    (hyst_en_o),
    .done_o       (done_o),
    .pg_timeout_o (pg_timeout_o),
    .seq_err_o    (seq_err_o)
);

// File: tb/pwr_seq_ctrl_tb.sv
module pwr_seq_ctrl_tb;

    localparam int CLK_NS = 10;
    localparam int NR     = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        run = 1'b0;
    logic        kill = 1'b0;
    logic        pg_en = 1'b1;
    logic [3:0]  good = '0;
    logic [15:0] dly = '0;
    logic [19:0] pgc = '0;

    logic [3:0] rail_en, hyst_en;
    logic       done, pg_to, serr, pg_busy;

    pwr_seq_ctrl u_dut (
        .clk          (clk),
        .rst          (rst),
        .run_i        (run),
        .rail_good_i  (good),
        .fault_kill_i (kill),
        .pg_enable_i  (pg_en),
        .dly_cycles_i (dly),
        .pg_cycles_i  (pgc),
        .rail_en_o    (rail_en),
        .hyst_en_o    (hyst_en),
        .done_o       (done),
        .pg_timeout_o (pg_to),
        .seq_err_o    (serr),
        .pg_busy_o    (pg_busy)
    );

    always #(CLK_NS/2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Observed vector: {serr, pg_to, done, hyst[3:0], en[3:0]}
    logic [10:0] obs;
    assign obs = {serr, pg_to, done, hyst_en, rail_en};

    typedef struct {
        int          at;
        logic [10:0] v;
        string       req;
    } exp_t;

    exp_t        sbq[$];
    int          n_chk = 0;
    int          n_fail = 0;
    logic [10:0] expv = '0;
    logic [10:0] prev_obs = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp_val);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp_val);
        end
    endtask

    task automatic push(input int at, input logic [10:0] v, input string req);
        exp_t e;
        e.at  = at;
        e.v   = v;
        e.req = req;
        sbq.push_back(e);
    endtask

    // Monitor: every output change must match the next queued expectation
    always @(negedge clk) begin
        if (!rst && obs !== prev_obs) begin
            if (sbq.size() == 0) begin
                chk(1'b0, "R8/any", "unexpected output change", int'(obs), int'(prev_obs));
            end else begin
                exp_t e;
                e = sbq.pop_front();
                chk(obs == e.v, e.req, "output value", int'(obs), int'(e.v));
                chk(cyc == e.at, e.req, "change cycle", cyc, e.at);
            end
            prev_obs = obs;
        end
    end

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic wait_until(input int t);
        while (cyc < t) step();
    endtask

    task automatic pwr_on(input int d, input int g, input int tmo_rail, input int p);
        int c, e;
        step();
        run = 1'b1;
        c = cyc;
        e = c + 4 + d;
        expv[0] = 1'b1;
        push(e, expv, "R2");
        for (int k = 0; k < 4; k++) begin
            wait_until(e);
            if (k == tmo_rail) begin
                push(e + p + 1, expv | 11'h200, "R7");
                push(e + p + 2, expv, "R7");
                repeat (p + 4) step();
            end else begin
                repeat (g) step();
            end
            good[k] = 1'b1;
            c = cyc;
            expv[4+k] = 1'b1;
            if (k == 3) expv[8] = 1'b1;
            push(c + 3, expv, (k == 3) ? "R5" : "R4");
            if (k < 3) begin
                e = c + 4 + d;
                expv[k+1] = 1'b1;
                push(e, expv, "R3");
            end else begin
                wait_until(c + 3);
            end
        end
    endtask

    task automatic pwr_off(input int d, input int g, input int hold);
        int c, e;
        step();
        run = 1'b0;
        c = cyc;
        expv[3] = 1'b0;
        push(c + 3, expv, "R6");
        wait_until(c + 3);
        for (int k = 3; k >= 0; k--) begin
            repeat ((k == 3) ? hold : g) step();
            good[k] = 1'b0;
            c = cyc;
            expv[4+k] = 1'b0;
            if (k == 0) expv[8] = 1'b0;
            push(c + 3, expv, (k == 0) ? "R5" : "R4");
            if (k > 0) begin
                e = c + 4 + d;
                expv[k-1] = 1'b0;
                push(e, expv, "R6");
                wait_until(e);
            end else begin
                wait_until(c + 3);
            end
        end
    endtask

    initial begin
        int c, e;
        dly = 16'd3;
        pgc = 20'd20;
        repeat (3) step();
        rst = 1'b0;
        step();
        chk(obs == 11'h0, "R1", "outputs after reset", int'(obs), 0);
        repeat (4) step();
        chk(obs == 11'h0 && pg_busy == 1'b0, "R1", "idle outputs", int'(obs), 0);

        // Normal power-on and power-off, delay 3
        pwr_on(3, 2, -1, 20);
        pwr_off(3, 2, 2);

        // Zero delay; long hold in power-off must not raise a timeout (R8)
        dly = 16'd0;
        pwr_on(0, 1, -1, 20);
        pwr_off(0, 1, 30);
        repeat (3) step();
        chk(sbq.size() == 0 && obs == 11'h0, "R8", "no timeout during power-off",
            int'(obs), 0);

        // Watchdog timeout on rail 0, then fault kill with all rails up
        dly = 16'd2;
        pgc = 20'd6;
        pwr_on(2, 2, 0, 6);
        step();
        kill = 1'b1;
        c = cyc;
        expv = '0;
        push(c + 1, expv, "R9");
        #1;
        chk(rail_en == 4'h0, "R9", "enables in kill cycle", int'(rail_en), 0);
        wait_until(c + 1);
        step();
        kill = 1'b0;
        run  = 1'b0;
        good = '0;
        repeat (6) step();
        chk(obs == 11'h0, "R9", "outputs after kill released", int'(obs), 0);

        // Watchdog disabled, then run falls during power-on
        pg_en = 1'b0;
        dly = 16'd1;
        step();
        run = 1'b1;
        c = cyc;
        e = c + 5;
        expv[0] = 1'b1;
        push(e, expv, "R2");
        wait_until(e);
        repeat (15) step();
        good[0] = 1'b1;
        c = cyc;
        expv[4] = 1'b1;
        push(c + 3, expv, "R4");
        e = c + 5;
        expv[1] = 1'b1;
        push(e, expv, "R3");
        wait_until(e);
        chk(sbq.size() == 0 && pg_to == 1'b0, "R8", "no timeout while disabled",
            int'(pg_to), 0);
        repeat (3) step();
        run = 1'b0;
        c = cyc;
        expv = '0;
        push(c + 3, 11'h400, "R10");
        push(c + 4, 11'h000, "R10");
        wait_until(c + 4);
        good = '0;
        repeat (6) step();

        // Run rises again during power-off
        pg_en = 1'b1;
        pgc = 20'd20;
        dly = 16'd2;
        pwr_on(2, 2, -1, 20);
        step();
        run = 1'b0;
        c = cyc;
        expv[3] = 1'b0;
        push(c + 3, expv, "R6");
        wait_until(c + 3);
        repeat (4) step();
        run = 1'b1;
        c = cyc;
        expv = '0;
        push(c + 3, 11'h400, "R10");
        push(c + 4, 11'h000, "R10");
        wait_until(c + 4);
        run  = 1'b0;
        good = '0;
        repeat (6) step();

        // Recovery run
        dly = 16'd1;
        pwr_on(1, 3, -1, 20);
        pwr_off(1, 3, 3);
        repeat (5) step();
        chk(sbq.size() == 0, "R6", "all expected changes seen", sbq.size(), 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule